// File: doc/BRIEF.md
# Strap-Selected Watchdog Start Controller

This block decides when a watchdog starts counting and which events may stop it. A start-strap input is looked at only while the reset pin or the hardware power-down pin is active. If the strap is high at that time, the watchdog starts by itself once the hold condition ends. The same strap also locks out the idle and power-down modes that software would otherwise request. Software can start the watchdog instead, by writing 1 to a start bit. The reload value can be programmed first, and it then applies from the first period.

A small down-counter is included so that the start and stop rules can be observed. On every load (start, refresh or timeout) it takes the reload value as its upper bits, with zeros below. It counts down once per clock. When a period runs out it gives a one-cycle timeout pulse and reloads. Once the watchdog runs, software cannot stop it. Only a reset-pin assertion with the strap low, or any hardware power-down, clears it. At the board level the strap is expected to have a weak pull-up, so a floating pin gives the automatic start.

All inputs are sampled on the rising clock edge. The hold condition is the reset pin or the power-down pin being high. These are plain control pins, and the block has no data stream, so there is no valid/ready handshake.

Top module: `wdt_start_ctrl`

## Requirements
- R1: If the strap is high during the hold condition (reset pin or power-down), the watchdog runs from the first clock edge at which the hold condition is low, and the counter is loaded on that edge.
- R2: The strap is ignored while the hold condition is low: a strap rise in normal operation neither starts the watchdog nor changes the power-save block output.
- R3: The power-save block output takes the strap level seen during the last hold cycle and keeps it until the next hold condition.
- R4: The reload register returns to its default of 0 during any hold. A reload value of 0 gives the longest period, 2^CNT_W cycles, so a hardware start uses that period.
- R5: Reload writes are accepted whenever the hold condition is low, whether the watchdog is running or not. A written value is used only at the next load, never by the count already under way.
- R6: A start-bit write with data 1, outside the hold condition, sets the running flag on that edge. The first period uses the reload value present at that edge.
- R7: A start-bit write of 0, or a start write while running, has no effect: the running flag stays set and the count goes on undisturbed.
- R8: A reset-pin hold with the strap low clears the running flag on the next edge. A power-down hold clears it on the next edge whatever the strap level.
- R9: A reset-pin hold with the strap high (power-down low) keeps the running flag set and freezes the count. On release, the count restarts at the default period.
- R10: A period of P cycles, counted from the loading edge, ends with timeout high for exactly one cycle, P edges after the load. The counter reloads on that same edge and the running flag stays set. P is reload*2^(CNT_W-RLD_W), or 2^CNT_W when reload is 0.
- R11: A refresh strobe while running reloads the counter, so the next timeout comes one full period after the refresh edge.
- R12: The start-bit read-back output equals the running flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_pin_i | input | 1 | Reset pin, active high |
| hwpd_i | input | 1 | Hardware power-down pin, active high |
| strap_i | input | 1 | Start strap, sampled only during hold |
| sw_start_wr_i | input | 1 | Write strobe for the software start bit |
| sw_start_wdata_i | input | 1 | Data written to the start bit |
| sw_start_rd_o | output | 1 | Start bit read-back (equals running) |
| reload_wr_i | input | 1 | Reload register write strobe |
| reload_wdata_i | input | RLD_W | Reload value written |
| refresh_i | input | 1 | Watchdog refresh strobe |
| running_o | output | 1 | Watchdog running flag |
| timeout_o | output | 1 | One-cycle timeout pulse |
| psave_block_o | output | 1 | Blocks software idle and power-down entry |

## Verification
The bench builds the block with CNT_W = 12 and RLD_W = 4. With these values a reload step is 256 cycles and the default period is 4096 cycles. Several full default periods therefore fit in a short run, next to the shorter 256- and 512-cycle periods. A scoreboard checks every timeout against its expected cycle. That covers periods after a software start, after a strap-started release from reset and from power-down, after a mid-period reload write, and after a refresh.

// File: rtl/wdt_start_pkg.sv
package wdt_start_pkg;
  typedef enum logic [1:0] {
    LOAD_NONE  = 2'd0,
    LOAD_START = 2'd1,
    LOAD_FRESH = 2'd2,
    LOAD_WRAP  = 2'd3
  } load_cause_e;

  function automatic int unsigned low_bits(input int unsigned cnt_w, input int unsigned rld_w);
    return cnt_w - rld_w;
  endfunction
endpackage

// File: rtl/wdt_hold_sampler.sv
module wdt_hold_sampler (
  input  logic clk_i,
  input  logic rst_pin_i,
  input  logic hwpd_i,
  input  logic strap_i,
  output logic hold_o,
  output logic kill_o,
  output logic armed_o,
  output logic hw_start_o
);
  logic hold_q;
  logic armed_q;

  assign hold_o = rst_pin_i | hwpd_i;
  // a hold stops the watchdog unless it is a pin reset with the strap high
  assign kill_o = hwpd_i | (rst_pin_i & ~strap_i);

  always_ff @(posedge clk_i) begin
    hold_q <= hold_o;
    if (hold_o) begin
      armed_q <= strap_i;
    end
  end

  assign armed_o    = armed_q;
  assign hw_start_o = ~hold_o & hold_q & armed_q;
endmodule

// File: rtl/wdt_reload_reg.sv
module wdt_reload_reg #(
  parameter int unsigned RLD_W = 8,
  parameter logic [RLD_W-1:0] RLD_DEFAULT = '0
) (
  input  logic             clk_i,
  input  logic             hold_i,
  input  logic             wr_i,
  input  logic [RLD_W-1:0] wdata_i,
  output logic [RLD_W-1:0] value_o
);
  logic [RLD_W-1:0] value_q;

  always_ff @(posedge clk_i) begin
    if (hold_i) begin
      value_q <= RLD_DEFAULT;
    end else if (wr_i) begin
      value_q <= wdata_i;
    end
  end

  assign value_o = value_q;
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter
  import wdt_start_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned RLD_W = 8
) (
  input  logic             clk_i,
  input  logic             hold_i,
  input  logic             kill_i,
  input  logic             hw_start_i,
  input  logic             sw_start_i,
  input  logic             refresh_i,
  input  logic [RLD_W-1:0] reload_i,
  output logic             running_o,
  output logic             timeout_o
);
  localparam int unsigned LOW_W = low_bits(CNT_W, RLD_W);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;
  logic             running_q;
  logic             timeout_q;
  load_cause_e      cause;

  assign load_val = {reload_i, {LOW_W{1'b0}}};

  always_comb begin
    cause = LOAD_NONE;
    if (!hold_i) begin
      if (hw_start_i || (sw_start_i && !running_q)) begin
        cause = LOAD_START;
      end else if (running_q && refresh_i) begin
        cause = LOAD_FRESH;
      end else if (running_q && cnt_q == CNT_W'(1)) begin
        cause = LOAD_WRAP;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    timeout_q <= 1'b0;
    if (hold_i) begin
      // count frozen; only the kill rule decides the flag
      running_q <= ~kill_i;
    end else begin
      case (cause)
        LOAD_START: begin
          running_q <= 1'b1;
          cnt_q     <= load_val;
        end
        LOAD_FRESH: cnt_q <= load_val;
        LOAD_WRAP: begin
          cnt_q     <= load_val;
          timeout_q <= 1'b1;
        end
        default: begin
          if (running_q) begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
      endcase
    end
  end

  assign running_o = running_q;
  assign timeout_o = timeout_q;
endmodule

// File: rtl/wdt_start_ctrl.sv
module wdt_start_ctrl #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned RLD_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_pin_i,
  input  logic             hwpd_i,
  input  logic             strap_i,
  input  logic             sw_start_wr_i,
  input  logic             sw_start_wdata_i,
  output logic             sw_start_rd_o,
  input  logic             reload_wr_i,
  input  logic [RLD_W-1:0] reload_wdata_i,
  input  logic             refresh_i,
  output logic             running_o,
  output logic             timeout_o,
  output logic             psave_block_o
);
  logic hold;
  logic kill;
  logic armed;
  logic hw_start;
  logic sw_start;
  logic [RLD_W-1:0] reload_val;

  wdt_hold_sampler u_hold (
    .clk_i      (clk_i),
    .rst_pin_i  (rst_pin_i),
    .hwpd_i     (hwpd_i),
    .strap_i    (strap_i),
    .hold_o     (hold),
    .kill_o     (kill),
    .armed_o    (armed),
    .hw_start_o (hw_start)
  );

  wdt_reload_reg #(.RLD_W(RLD_W), .RLD_DEFAULT('0)) u_reload (
    .clk_i   (clk_i),
    .hold_i  (hold),
    .wr_i    (reload_wr_i),
    .wdata_i (reload_wdata_i),
    .value_o (reload_val)
  );

  assign sw_start = sw_start_wr_i & sw_start_wdata_i;

  wdt_down_counter #(.CNT_W(CNT_W), .RLD_W(RLD_W)) u_cnt (
    .clk_i      (clk_i),
    .hold_i     (hold),
    .kill_i     (kill),
    .hw_start_i (hw_start),
    .sw_start_i (sw_start),
    .refresh_i  (refresh_i),
    .reload_i   (reload_val),
    .running_o  (running_o),
    .timeout_o  (timeout_o)
  );

  assign sw_start_rd_o = running_o;
  assign psave_block_o = armed;
endmodule

// File: rtl/wdt_start_ctrl_sva.sv
module wdt_start_ctrl_sva (
  input logic clk_i,
  input logic rst_pin_i,
  input logic hwpd_i,
  input logic strap_i,
  input logic sw_start_wr_i,
  input logic sw_start_wdata_i,
  input logic sw_start_rd_o,
  input logic refresh_i,
  input logic running_o,
  input logic timeout_o,
  input logic psave_block_o
);
  logic seen = 1'b0;
  always_ff @(posedge clk_i) seen <= seen | rst_pin_i | hwpd_i;

  a_r8_pin_reset_clears: assert property (@(posedge clk_i) disable iff (!seen)
    (rst_pin_i && !hwpd_i && !strap_i) |=> !running_o);
  a_r8_hwpd_clears: assert property (@(posedge clk_i) disable iff (!seen)
    hwpd_i |=> !running_o);
  a_r9_strap_reset_keeps: assert property (@(posedge clk_i) disable iff (!seen)
    (rst_pin_i && !hwpd_i && strap_i) |=> running_o);
  a_r3_psave_samples: assert property (@(posedge clk_i) disable iff (!seen)
    (rst_pin_i || hwpd_i) |=> (psave_block_o == $past(strap_i)));
  a_r2_psave_steady: assert property (@(posedge clk_i) disable iff (!seen)
    !(rst_pin_i || hwpd_i) |=> $stable(psave_block_o));
  a_r7_no_sw_stop: assert property (@(posedge clk_i) disable iff (!seen)
    (running_o && !rst_pin_i && !hwpd_i) |=> running_o);
  a_r2_no_stray_start: assert property (@(posedge clk_i) disable iff (!seen)
    (!running_o && !rst_pin_i && !hwpd_i && !$past(rst_pin_i || hwpd_i)
     && !(sw_start_wr_i && sw_start_wdata_i)) |=> !running_o);
  a_r6_sw_start: assert property (@(posedge clk_i) disable iff (!seen)
    (!rst_pin_i && !hwpd_i && sw_start_wr_i && sw_start_wdata_i) |=> running_o);
  a_r10_single_pulse: assert property (@(posedge clk_i) disable iff (!seen)
    timeout_o |=> !timeout_o);
  a_r10_stays_running: assert property (@(posedge clk_i) disable iff (!seen)
    timeout_o |-> running_o);
  a_r12_readback: assert property (@(posedge clk_i) disable iff (!seen)
    sw_start_rd_o == running_o);
endmodule

bind wdt_start_ctrl wdt_start_ctrl_sva u_sva (
  .clk_i            (clk_i),
  .rst_pin_i        (rst_pin_i),
  .hwpd_i           (hwpd_i),
  .strap_i          (strap_i),
  .sw_start_wr_i    (sw_start_wr_i),
  .sw_start_wdata_i (sw_start_wdata_i),
  .sw_start_rd_o    (sw_start_rd_o),
  .refresh_i        (refresh_i),
  .running_o        (running_o),
  .timeout_o        (timeout_o),
  .psave_block_o    (psave_block_o)
);

// File: tb/tb_wdt_start_ctrl.sv
module tb_wdt_start_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 12;
  localparam int RLD_W = 4;
  localparam int LOW_W = CNT_W - RLD_W;

  logic clk = 1'b0;
  logic rst_pin = 1'b1, hwpd = 1'b0, strap = 1'b0;
  logic sw_wr = 1'b0, sw_data = 1'b0, rl_wr = 1'b0, refresh = 1'b0;
  logic [RLD_W-1:0] rl_data = '0;
  logic sw_rd, running, timeout, psave;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_start_ctrl #(.CNT_W(CNT_W), .RLD_W(RLD_W)) dut (
    .clk_i(clk), .rst_pin_i(rst_pin), .hwpd_i(hwpd), .strap_i(strap),
    .sw_start_wr_i(sw_wr), .sw_start_wdata_i(sw_data), .sw_start_rd_o(sw_rd),
    .reload_wr_i(rl_wr), .reload_wdata_i(rl_data), .refresh_i(refresh),
    .running_o(running), .timeout_o(timeout), .psave_block_o(psave)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  int exp_q[$];
  bit mon_en = 1'b0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at cycle %0d", req, act, expv, cyc);
    end
  endtask

  function automatic int period(input int r);
    return (r == 0) ? (1 << CNT_W) : (r << LOW_W);
  endfunction

  // monitor: every timeout must match the front of the expected queue
  always @(negedge clk) begin
    if (mon_en && timeout === 1'b1) begin
      if (exp_q.size() == 0) check(1'b0, "R10 unexpected timeout", cyc, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        check(e == cyc, "R10 timeout cycle", cyc, e);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic drain;
    while (exp_q.size() != 0) @(negedge clk);
    tick(2);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    int s, q;
    tick(4);
    mon_en = 1'b1;
    // reset with strap low
    check(running == 1'b0, "R8 running after strap-low reset", running, 0);
    check(psave == 1'b0, "R3 psave after strap-low reset", psave, 0);
    check(sw_rd == 1'b0, "R12 readback idle", sw_rd, 0);
    rst_pin = 1'b0;
    tick(5);
    check(running == 1'b0, "R1 no start with strap low", running, 0);
    strap = 1'b1;
    tick(10);
    check(running == 1'b0, "R2 strap rise ignored (running)", running, 0);
    check(psave == 1'b0, "R2 strap rise ignored (psave)", psave, 0);
    strap = 1'b0;

    // program reload before software start
    rl_wr = 1'b1; rl_data = 4'd1; tick(1); rl_wr = 1'b0;
    sw_wr = 1'b1; sw_data = 1'b0; tick(1); sw_wr = 1'b0;
    tick(2);
    check(running == 1'b0, "R7 write of 0 does not start", running, 0);
    sw_wr = 1'b1; sw_data = 1'b1;
    s = cyc + 1;
    exp_q.push_back(s + period(1));          // R6 first period uses programmed value
    exp_q.push_back(s + 2 * period(1));      // R5 mid-period write not yet used
    tick(1); sw_wr = 1'b0;
    check(running == 1'b1, "R6 software start", running, 1);
    check(sw_rd == 1'b1, "R12 readback running", sw_rd, 1);
    wait_to(s + 100);
    sw_wr = 1'b1; sw_data = 1'b1; tick(1); sw_wr = 1'b0;   // R7 restart attempt ignored
    wait_to(s + 150);
    sw_wr = 1'b1; sw_data = 1'b0; tick(1); sw_wr = 1'b0;
    check(running == 1'b1, "R7 write of 0 does not stop", running, 1);
    wait_to(s + 300);
    rl_wr = 1'b1; rl_data = 4'd2; tick(1); rl_wr = 1'b0;   // R5
    wait_to(s + 700);
    refresh = 1'b1;
    exp_q.push_back(cyc + 1 + period(2));    // R11 refresh, R5 new value now in use
    tick(1); refresh = 1'b0;
    drain();
    check(running == 1'b1, "R10 running after timeout", running, 1);

    // pin reset with strap high while running
    rst_pin = 1'b1; strap = 1'b1;
    tick(1);
    check(running == 1'b1, "R9 running kept in strap-high reset", running, 1);
    tick(3);
    rst_pin = 1'b0;
    exp_q.push_back(cyc + 1 + period(0));    // R9 / R4 default period
    tick(1);
    check(running == 1'b1, "R9 running after release", running, 1);
    check(psave == 1'b1, "R3 psave after strap-high reset", psave, 1);
    strap = 1'b0;
    tick(20);
    check(psave == 1'b1, "R2 psave kept after strap drop", psave, 1);
    drain();

    // pin reset with strap low stops it
    rst_pin = 1'b1; strap = 1'b0;
    tick(1);
    check(running == 1'b0, "R8 strap-low reset stops", running, 0);
    check(psave == 1'b0, "R3 psave cleared", psave, 0);
    tick(2); rst_pin = 1'b0;
    tick(30);
    check(running == 1'b0, "R1 stays stopped after strap-low reset", running, 0);

    // power-down with strap high
    hwpd = 1'b1; strap = 1'b1;
    tick(1);
    check(running == 1'b0, "R8 power-down holds stopped", running, 0);
    check(psave == 1'b1, "R3 psave from power-down strap", psave, 1);
    tick(3); hwpd = 1'b0;
    tick(1);
    check(running == 1'b1, "R1 start after power-down release", running, 1);
    tick(40);
    hwpd = 1'b1;
    tick(1);
    check(running == 1'b0, "R8 power-down stops despite strap high", running, 0);
    tick(2); hwpd = 1'b0;
    exp_q.push_back(cyc + 1 + period(0));    // R1 / R4
    tick(1);
    check(running == 1'b1, "R1 restart after power-down", running, 1);
    drain();
    tick(10);
    check(exp_q.size() == 0, "R10 all timeouts seen", exp_q.size(), 0);
    finish_run();
  end
endmodule